// File: doc/BRIEF.md
# Smoothed Digital Attenuation Ramp

This block scales a stream of signed 16-bit audio samples by a gain taken from a 7-bit attenuation code. Code 7F is unity gain (0 dB) and code 00 is silence. A larger code never gives a smaller level. The gain never jumps. A 10-bit internal gain moves by at most one LSB on each sample strobe toward the level of the last code written. A complete sweep therefore takes 1023 samples, which is about 23.2 ms at 44.1 kHz.

A new code can be written at any time. If it arrives in the middle of a ramp, the ramp changes direction at once and continues from the gain it has reached, not from the old end point. Each sample strobe produces one registered output sample in the next cycle. That sample is scaled by the gain held before the strobe's own step.

Top module: `smooth_atten`

## Requirements
- R1: While reset is asserted, and after it is released, the gain and the target are both 1023 (full scale), `smp_out` is 0 and `smp_out_valid` is low. The first sample after reset is passed through unchanged.
- R2: A write of code c sets the target to the 10-bit value {c[6:0], c[6:4]}. Code 00 gives 0 and code 7F gives 1023, and the mapping is monotonic.
- R3: Each cycle with `smp_valid` high moves the gain by exactly one LSB toward the target. In cycles without `smp_valid` the gain does not change.
- R4: When the gain equals the target, a sample strobe leaves the gain unchanged.
- R5: A code write during a ramp redirects the ramp. The next steps start from the present gain and move toward the new target.
- R6: A strobe in cycle t makes `smp_out_valid` high in cycle t+1 only. `smp_out` is then in×g/1024 truncated toward zero, where g is the gain before that strobe's step.
- R7: At gain 1023 the output equals the input exactly, including -32768.
- R8: At gain 0 the output is exactly 0 for any input.
- R9: When a code write and a sample strobe fall in the same cycle, that cycle's step moves toward the previously held target. The new target applies from the next strobe onward.
- R10: A sweep from gain 0 to gain 1023 takes exactly 1023 sample strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_we | input | 1 | Attenuation code write strobe |
| code_wdata | input | 7 | Attenuation code, 7F = 0 dB, 00 = mute |
| smp_valid | input | 1 | Input sample strobe, also the ramp step enable |
| smp_in | input | 16 | Signed input sample |
| smp_out | output | 16 | Signed scaled output sample |
| smp_out_valid | output | 1 | High for one cycle when smp_out holds a new result |

## Verification
The bench targets rounding of negative products. A design that shifts arithmetically would return -3 instead of -2 for -3 at gain 1019. It also checks the exact pass-through at full gain: a plain multiply by 1023/1024 would turn 16384 into 16368. A redirect in the middle of a ramp is checked to turn back from the intermediate gain; a design that finishes the old ramp first would keep falling. The bench also covers a write that shares a cycle with a strobe, holding at the target without oscillation, the full 1023-strobe sweep, and silence at zero gain, where a biased rounding scheme could leak -1.

// File: rtl/gainramp_pkg.sv
package gainramp_pkg;

    parameter int SMP_W  = 16;
    parameter int CODE_W = 7;
    parameter int GAIN_W = 10;

    localparam int PROD_W = SMP_W + GAIN_W + 1;
    localparam logic [GAIN_W-1:0] GAIN_MAX = {GAIN_W{1'b1}};

    typedef logic [CODE_W-1:0]        code_t;
    typedef logic [GAIN_W-1:0]        gain_t;
    typedef logic signed [SMP_W-1:0]  smp_t;
    typedef logic signed [PROD_W-1:0] prod_t;

    typedef enum logic [1:0] {
        SLEW_HOLD = 2'd0,
        SLEW_UP   = 2'd1,
        SLEW_DOWN = 2'd2
    } slew_dir_e;

    typedef struct packed {
        logic vld;
        smp_t data;
    } smp_beat_t;

    // Widen a code to gain width by repeating its bits from the MSB down.
    // Gives all-zero for code zero, all-ones for the top code, and keeps order.
    function automatic gain_t code_to_gain(input code_t c);
        gain_t g;
        for (int i = 0; i < GAIN_W; i++) begin
            g[GAIN_W-1-i] = c[CODE_W-1-(i % CODE_W)];
        end
        return g;
    endfunction

endpackage

// File: rtl/atten_target_reg.sv
module atten_target_reg
    import gainramp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  code_t code,
    output gain_t tgt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tgt <= GAIN_MAX;
        end else if (we) begin
            tgt <= code_to_gain(code);
        end
    end
endmodule

// File: rtl/atten_slew.sv
module atten_slew
    import gainramp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  step_en,
    input  gain_t tgt,
    output gain_t gain
);
    slew_dir_e dir;

    always_comb begin
        if (gain == tgt) begin
            dir = SLEW_HOLD;
        end else if (gain < tgt) begin
            dir = SLEW_UP;
        end else begin
            dir = SLEW_DOWN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gain <= GAIN_MAX;
        end else if (step_en) begin
            case (dir)
                SLEW_UP:   gain <= gain + 1'b1;
                SLEW_DOWN: gain <= gain - 1'b1;
                default:   gain <= gain;
            endcase
        end
    end
endmodule

// File: rtl/atten_scaler.sv
module atten_scaler
    import gainramp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  smp_beat_t beat_in,
    input  gain_t     gain,
    output smp_beat_t beat_out
);
    localparam prod_t BIAS = prod_t'(GAIN_MAX);

    prod_t prod;
    prod_t biased;
    prod_t shifted;
    smp_t  scaled;

    always_comb begin
        prod    = $signed(beat_in.data) * $signed({1'b0, gain});
        // Adding divisor-1 before the shift makes negative results truncate toward zero
        biased  = prod[PROD_W-1] ? (prod + BIAS) : prod;
        shifted = biased >>> GAIN_W;
        if (gain == GAIN_MAX) begin
            scaled = beat_in.data;
        end else begin
            scaled = shifted[SMP_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_out <= '0;
        end else begin
            beat_out.vld <= beat_in.vld;
            if (beat_in.vld) begin
                beat_out.data <= scaled;
            end
        end
    end
endmodule

// File: rtl/smooth_atten.sv
module smooth_atten
    import gainramp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              code_we,
    input  logic [CODE_W-1:0] code_wdata,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_in,
    output logic [SMP_W-1:0]  smp_out,
    output logic              smp_out_valid
);
    gain_t     tgt_q;
    gain_t     gain_q;
    smp_beat_t beat_in;
    smp_beat_t beat_out;

    assign beat_in.vld  = smp_valid;
    assign beat_in.data = smp_in;

    atten_target_reg tgt_i (
        .clk  (clk),
        .rst  (rst),
        .we   (code_we),
        .code (code_wdata),
        .tgt  (tgt_q)
    );

    atten_slew slew_i (
        .clk     (clk),
        .rst     (rst),
        .step_en (smp_valid),
        .tgt     (tgt_q),
        .gain    (gain_q)
    );

    atten_scaler scale_i (
        .clk      (clk),
        .rst      (rst),
        .beat_in  (beat_in),
        .gain     (gain_q),
        .beat_out (beat_out)
    );

    assign smp_out       = beat_out.data;
    assign smp_out_valid = beat_out.vld;
endmodule

// File: rtl/atten_chk.sv
module atten_chk
    import gainramp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              code_we,
    input logic [CODE_W-1:0] code_wdata,
    input logic              smp_valid,
    input logic [SMP_W-1:0]  smp_in,
    input logic [SMP_W-1:0]  smp_out,
    input logic              smp_out_valid,
    input logic [GAIN_W-1:0] gain,
    input logic [GAIN_W-1:0] tgt
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (gain == GAIN_MAX && tgt == GAIN_MAX && !smp_out_valid));

    // R2
    code_low_chk: assert property (@(posedge clk) disable iff (rst)
        (code_we && code_wdata == '0) |=> (tgt == '0));

    // R2
    code_high_chk: assert property (@(posedge clk) disable iff (rst)
        (code_we && code_wdata == {CODE_W{1'b1}}) |=> (tgt == GAIN_MAX));

    // R3
    idle_gain_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(gain));

    // R3
    step_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && gain != tgt) |=>
            (($past(gain) < $past(tgt) && gain == $past(gain) + 1'b1) ||
             ($past(gain) > $past(tgt) && gain == $past(gain) - 1'b1)));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && gain == tgt) |=> $stable(gain));

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> smp_out_valid);

    // R6
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> !smp_out_valid);

    // R7
    unity_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && gain == GAIN_MAX) |=> (smp_out == $past(smp_in)));

    // R8
    mute_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && gain == '0) |=> (smp_out == '0));
endmodule

bind smooth_atten atten_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .code_we       (code_we),
    .code_wdata    (code_wdata),
    .smp_valid     (smp_valid),
    .smp_in        (smp_in),
    .smp_out       (smp_out),
    .smp_out_valid (smp_out_valid),
    .gain          (gain_q),
    .tgt           (tgt_q)
);

// File: tb/smooth_atten_tb.sv
module smooth_atten_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int GMAX = 1023;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        code_we = 1'b0;
    logic [6:0]  code_wdata = '0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_in = '0;
    logic [15:0] smp_out;
    logic        smp_out_valid;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    int m_gain;
    int m_tgt;

    always #(CLK_PERIOD/2) clk = ~clk;

    smooth_atten dut_i (
        .clk           (clk),
        .rst           (rst),
        .code_we       (code_we),
        .code_wdata    (code_wdata),
        .smp_valid     (smp_valid),
        .smp_in        (smp_in),
        .smp_out       (smp_out),
        .smp_out_valid (smp_out_valid)
    );

    typedef struct packed {
        logic        wr;
        logic [6:0]  code;
        logic [15:0] din;
        logic [15:0] dout;
    } vec_t;

    // Starts right after reset with gain = target = 1023
    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 7'h00, 16'd1000, 16'd1000},   // R7 pass-through
        '{1'b0, 7'h00, 16'h8000, 16'h8000},   // R7 most negative input
        '{1'b1, 7'h7E, 16'h0000, 16'h0000},   // R2 target becomes 1015
        '{1'b0, 7'h00, 16'h4000, 16'h4000},   // gain 1023 -> unity
        '{1'b0, 7'h00, 16'h4000, 16'h3FE0},   // R3 gain 1022
        '{1'b0, 7'h00, 16'hC000, 16'hC030},   // R6 gain 1021 negative
        '{1'b0, 7'h00, 16'd3,    16'd2},      // R6 trunc 2.98 -> 2
        '{1'b0, 7'h00, 16'hFFFD, 16'hFFFE},   // R6 trunc -2.98 -> -2
        '{1'b1, 7'h7F, 16'h0000, 16'h0000},   // R5 redirect upward at 1018
        '{1'b0, 7'h00, 16'h4000, 16'h3FA0},   // R5 gain 1018 used, then 1019
        '{1'b0, 7'h00, 16'h4000, 16'h3FB0}    // R5 gain 1019 -> rising
    };

    function automatic int tgt_of(input int c);
        return c * 8 + c / 16;
    endfunction

    function automatic int exp_of(input int din, input int g);
        if (g == GMAX) return din;
        return (din * g) / 1024;
    endfunction

    task automatic chk(input string req, input bit ok, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_step();
        if (m_gain < m_tgt) m_gain++;
        else if (m_gain > m_tgt) m_gain--;
    endtask

    task automatic write_code(input int c);
        @(negedge clk);
        code_we = 1'b1;
        code_wdata = 7'(c);
        @(negedge clk);
        code_we = 1'b0;
        m_tgt = tgt_of(c);
    endtask

    // Drive one strobe; compare against the explicit expectation
    task automatic sample_exp(input string req, input int din, input int exp);
        int act;
        @(negedge clk);
        smp_valid = 1'b1;
        smp_in = 16'(din);
        @(negedge clk);
        smp_valid = 1'b0;
        act = int'($signed(smp_out));
        chk({req, " valid"}, smp_out_valid === 1'b1, int'(smp_out_valid), 1);
        chk(req, act == exp, act, exp);
        model_step();
    endtask

    task automatic sample_model(input string req, input int din);
        sample_exp(req, din, exp_of(din, m_gain));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int act;
        m_gain = GMAX;
        m_tgt = GMAX;
        repeat (4) @(negedge clk);
        // R1 outputs during reset
        chk("R1 out_valid in reset", smp_out_valid === 1'b0, int'(smp_out_valid), 0);
        chk("R1 out in reset", smp_out === 16'h0, int'(smp_out), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 out_valid after reset", smp_out_valid === 1'b0, int'(smp_out_valid), 0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                write_code(int'(VECS[i].code));
            end else begin
                sample_exp($sformatf("R6 vec%0d", i), int'($signed(VECS[i].din)),
                           int'($signed(VECS[i].dout)));
            end
        end

        // R6 valid is a single-cycle pulse
        @(negedge clk);
        chk("R6 no valid without strobe", smp_out_valid === 1'b0, int'(smp_out_valid), 0);

        // R3 idle cycles leave gain untouched (gain 1020 here)
        repeat (50) @(negedge clk);
        sample_exp("R3 idle keeps gain", 16384, 16 * 1020);

        // Ramp down to mute, checking every step
        write_code(0);
        while (m_gain != 0) sample_model("R3 ramp down", 16384);
        // R8 mute gives zero for extremes
        sample_exp("R8 mute positive", 32767, 0);
        sample_exp("R8 mute negative", -32768, 0);
        sample_exp("R8 mute minus one", -1, 0);
        // R4 held at target
        sample_exp("R4 hold at zero", 16384, 0);

        // R9 write together with strobe: step uses old target 0
        @(negedge clk);
        code_we = 1'b1;
        code_wdata = 7'h7F;
        smp_valid = 1'b1;
        smp_in = 16'd16384;
        @(negedge clk);
        code_we = 1'b0;
        smp_valid = 1'b0;
        act = int'($signed(smp_out));
        chk("R9 same-cycle output", act == 0, act, 0);
        m_tgt = GMAX;
        sample_exp("R9 gain still 0", 16384, 0);
        sample_exp("R9 gain now 1", 16384, 16);

        // R10 full sweep 0 -> 1023 is 1023 strobes; 2 already taken
        for (int k = 2; k < 1022; k++) sample_model("R10 sweep", 16384);
        sample_exp("R10 strobe 1023 uses 1022", 16384, 16 * 1022);
        sample_exp("R10 reached full scale", 16384, 16384);
        sample_exp("R4 hold at full scale", 16384, 16384);

        // R2 mapping for a few codes, settled and read back via 16384 input
        write_code(7'h40);
        while (m_gain != m_tgt) sample_model("R2 settle 40", 16384);
        sample_exp("R2 code 40 -> 516", 16384, 16 * 516);
        write_code(7'h01);
        while (m_gain != m_tgt) sample_model("R2 settle 01", 16384);
        sample_exp("R2 code 01 -> 8", 16384, 16 * 8);

        // R5 redirect downward mid-ramp
        write_code(7'h7F);
        repeat (5) sample_model("R5 rise", 16384);
        write_code(7'h00);
        sample_exp("R5 turn from 13", 16384, 16 * 13);
        sample_exp("R5 falling 12", 16384, 16 * 12);

        // R1 reset mid-ramp restores full scale
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_gain = GMAX;
        m_tgt = GMAX;
        sample_exp("R1 pass after reset", -12345, -12345);
        sample_exp("R1 target full after reset", 4321, 4321);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule